// File: doc/BRIEF.md
# Pipeline Hazard Interlock Unit

This block is the stall and forwarding controller of an in-order five-stage integer pipeline whose stages run fetch, decode, execute, memory access and writeback. Each cycle it looks at the register fields, write enables and load/store flags of the instructions in decode, execute, memory and writeback. From these it decides whether fetch must hold, whether decode must hold, and which bubble to insert. It also picks the forwarding source for both execute operands and for the store data in the memory stage.

Three static mode pins select the hazard model. The first turns operand forwarding on or off. The second chooses one shared memory port or separate instruction and data ports. The third chooses a register file that cannot read and write in one cycle, or one that writes in the first half-cycle and reads in the second. Two free-running counters, one for cycles and one for instructions reaching writeback, let a test compute the CPI of a known instruction sequence.

Top module: `pipe_interlock`

## Requirements
- R1: With the shared memory mode (`cfg_split_mem`=0), a valid load or store in the memory stage forces `stall_pc`=1 in that cycle. With separate ports it does not.
- R2: With the single-port register file (`cfg_split_rf`=0), a valid writeback writing a nonzero register forces a decode stall whenever the decode instruction reads any register.
- R3: With the half-cycle register file (`cfg_split_rf`=1), a writeback to a register that decode reads never stalls decode.
- R4: With forwarding off, a decode source that matches the destination of a writing instruction in execute or memory stalls decode. The same holds for writeback when `cfg_split_rf`=0.
- R5: With forwarding on, decode stalls only when a load in execute writes a register that decode uses as an ALU operand. That is exactly one stall cycle per load-use pair.
- R6: Register 0 never causes a stall or a forwarding selection.
- R7: Operand selects use the encoding 0 = register file, 1 = from the execute/memory boundary, 2 = from the memory/writeback boundary. A non-load in memory wins over writeback when both match. A load in memory is never a source for select 1.
- R8: A load in execute matching only the store-data register of a store in decode does not stall. `fwd_sd`=1 when a store in memory has its data register written by a load in writeback (forwarding on, register nonzero).
- R9: A decode stall raises `stall_pc`, `stall_ifid` and `bubble_ex` and leaves `bubble_id`=0. A fetch-only stall raises `stall_pc` and `bubble_id` only.
- R10: `cycle_cnt` and `retire_cnt` are 0 after reset. `cycle_cnt` then rises by one each clock, and `retire_cnt` rises by one each clock with `wb_valid`=1.
- R11: With forwarding off, `fwd_a`, `fwd_b` and `fwd_sd` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_fwd_en | input | 1 | Forwarding enable |
| cfg_split_mem | input | 1 | 1 = separate instruction and data memory ports |
| cfg_split_rf | input | 1 | 1 = write first half-cycle, read second |
| id_valid | input | 1 | Decode stage holds an instruction |
| id_rs1 | input | REG_AW | Decode source 1 |
| id_rs2 | input | REG_AW | Decode source 2 / store data register |
| id_rs1_use | input | 1 | Source 1 is an ALU operand |
| id_rs2_use | input | 1 | Source 2 is an ALU operand |
| id_is_store | input | 1 | Decode instruction stores `id_rs2` |
| ex_valid | input | 1 | Execute stage holds an instruction |
| ex_rd | input | REG_AW | Execute destination |
| ex_wen | input | 1 | Execute instruction writes a register |
| ex_is_load | input | 1 | Execute instruction is a load |
| ex_rs1 | input | REG_AW | Execute source 1 |
| ex_rs2 | input | REG_AW | Execute source 2 / store data |
| ex_rs1_use | input | 1 | Execute reads source 1 |
| ex_rs2_use | input | 1 | Execute reads source 2 |
| mem_valid | input | 1 | Memory stage holds an instruction |
| mem_rd | input | REG_AW | Memory destination |
| mem_wen | input | 1 | Memory instruction writes a register |
| mem_is_load | input | 1 | Memory instruction is a load |
| mem_is_store | input | 1 | Memory instruction is a store |
| mem_rs2 | input | REG_AW | Store data register in memory |
| wb_valid | input | 1 | Writeback stage holds an instruction |
| wb_rd | input | REG_AW | Writeback destination |
| wb_wen | input | 1 | Writeback writes a register |
| wb_is_load | input | 1 | Writeback instruction is a load |
| stall_pc | output | 1 | Hold the program counter |
| stall_ifid | output | 1 | Hold the fetch/decode register |
| bubble_ex | output | 1 | Insert a no-op into execute |
| bubble_id | output | 1 | Insert a no-op into decode |
| fwd_a | output | 2 | Operand A source select |
| fwd_b | output | 2 | Operand B / store data select in execute |
| fwd_sd | output | 1 | Store data taken from writeback in memory |
| cycle_cnt | output | CNT_W | Cycles since reset |
| retire_cnt | output | CNT_W | Instructions reaching writeback |

## Verification
Every stall, bubble and select output is combinational on the stage fields, so it is due in the same cycle as its stimulus. The bench applies each input pattern and samples one nanosecond later, before the pattern changes. Both counters are registered and change at the rising edge after the cycle they count, so they are read on the falling edge that follows. The stall sweep covers all eight mode combinations over three register numbers (including register 0) and every stage kind. A second sweep covers the forwarding selects.

// File: rtl/pipe_interlock_pkg.sv
// Package: shared types for the pipeline hazard interlock unit.
// Assumes a register file indexed by an address whose value 0 is hard-wired zero.
package pipe_interlock_pkg;

    // Operand source select; values are part of the port contract.
    typedef enum logic [1:0] {
        SEL_REGFILE = 2'd0,
        SEL_EXMEM   = 2'd1,
        SEL_MEMWB   = 2'd2
    } op_sel_e;

    // True when a stage holds a real write to a nonzero register that equals src.
    function automatic logic producer_hit(
        input logic       valid,
        input logic       wen,
        input logic [7:0] rd,
        input logic [7:0] src
    );
        return valid && wen && (rd != 8'd0) && (rd == src);
    endfunction

endpackage

// File: rtl/pi_src_hazard.sv
// Module: pi_src_hazard
// Decides whether a single decode-stage source register must hold decode.
// Assumes producers in execute, memory and writeback; register 0 never conflicts.
// alu_use marks a source consumed in execute, any_use also covers store data.
module pi_src_hazard
    import pipe_interlock_pkg::*;
#(
    parameter int REG_AW = 5
) (
    input  logic              cfg_fwd_en,
    input  logic              cfg_split_rf,
    input  logic [REG_AW-1:0] src,
    input  logic              alu_use,
    input  logic              any_use,
    input  logic              ex_valid,
    input  logic [REG_AW-1:0] ex_rd,
    input  logic              ex_wen,
    input  logic              ex_is_load,
    input  logic              mem_valid,
    input  logic [REG_AW-1:0] mem_rd,
    input  logic              mem_wen,
    input  logic              wb_valid,
    input  logic [REG_AW-1:0] wb_rd,
    input  logic              wb_wen,
    output logic              hazard
);

    logic hit_ex, hit_mem, hit_wb;

    // Compare the source against each downstream producer.
    always_comb begin
        hit_ex  = producer_hit(ex_valid,  ex_wen,  8'(ex_rd),  8'(src));
        hit_mem = producer_hit(mem_valid, mem_wen, 8'(mem_rd), 8'(src));
        hit_wb  = producer_hit(wb_valid,  wb_wen,  8'(wb_rd),  8'(src));
    end

    // Forwarding leaves only the load-use case; without it every pending write holds.
    always_comb begin
        if (cfg_fwd_en) begin
            hazard = alu_use && hit_ex && ex_is_load;
        end else begin
            hazard = any_use && (hit_ex || hit_mem || (hit_wb && !cfg_split_rf));
        end
    end

endmodule

// File: rtl/pi_fwd_sel.sv
// Module: pi_fwd_sel
// Picks the bypass source for one execute-stage operand.
// Assumes a load in memory has no data yet at the execute/memory boundary.
module pi_fwd_sel
    import pipe_interlock_pkg::*;
#(
    parameter int REG_AW = 5
) (
    input  logic              cfg_fwd_en,
    input  logic [REG_AW-1:0] src,
    input  logic              src_use,
    input  logic              mem_valid,
    input  logic [REG_AW-1:0] mem_rd,
    input  logic              mem_wen,
    input  logic              mem_is_load,
    input  logic              wb_valid,
    input  logic [REG_AW-1:0] wb_rd,
    input  logic              wb_wen,
    output op_sel_e           sel
);

    logic near_hit, far_hit;

    // Nearest producer first; loads in memory are excluded from the near path.
    always_comb begin
        near_hit = producer_hit(mem_valid, mem_wen && !mem_is_load, 8'(mem_rd), 8'(src));
        far_hit  = producer_hit(wb_valid, wb_wen, 8'(wb_rd), 8'(src));
        sel      = SEL_REGFILE;
        if (cfg_fwd_en && src_use) begin
            if (near_hit) begin
                sel = SEL_EXMEM;
            end else if (far_hit) begin
                sel = SEL_MEMWB;
            end
        end
    end

endmodule

// File: rtl/pi_stall_ctrl.sv
// Module: pi_stall_ctrl
// Turns hazard causes into pipeline hold and bubble controls.
// Assumes a decode stall outranks a fetch-only stall.
module pi_stall_ctrl (
    input  logic data_hazard,
    input  logic rf_conflict,
    input  logic mem_conflict,
    output logic stall_pc,
    output logic stall_ifid,
    output logic bubble_ex,
    output logic bubble_id
);

    logic hold_decode;

    // Decode holds on either cause; fetch holds whenever decode holds or memory is busy.
    always_comb begin
        hold_decode = data_hazard || rf_conflict;
        stall_pc    = hold_decode || mem_conflict;
        stall_ifid  = hold_decode;
        bubble_ex   = hold_decode;
        bubble_id   = mem_conflict && !hold_decode;
    end

endmodule

// File: rtl/pi_event_cnt.sv
// Module: pi_event_cnt
// Counter that clears in reset and adds one each clock with inc set.
// Assumes wrap-around on overflow is acceptable.
module pi_event_cnt #(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             inc,
    output logic [CNT_W-1:0] count
);

    // Synchronous clear, then count qualifying cycles.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count <= '0;
        end else if (inc) begin
            count <= count + CNT_W'(1);
        end
    end

endmodule

// File: rtl/pipe_interlock.sv
// Module: pipe_interlock (top)
// Stall and forwarding control for a five-stage in-order integer pipeline.
// Static cfg_* pins select forwarding, memory porting and register-file timing.
// Assumes stage fields are valid only when the matching *_valid is set.
module pipe_interlock
    import pipe_interlock_pkg::*;
#(
    parameter int REG_AW = 5,
    parameter int CNT_W  = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_fwd_en,
    input  logic              cfg_split_mem,
    input  logic              cfg_split_rf,
    input  logic              id_valid,
    input  logic [REG_AW-1:0] id_rs1,
    input  logic [REG_AW-1:0] id_rs2,
    input  logic              id_rs1_use,
    input  logic              id_rs2_use,
    input  logic              id_is_store,
    input  logic              ex_valid,
    input  logic [REG_AW-1:0] ex_rd,
    input  logic              ex_wen,
    input  logic              ex_is_load,
    input  logic [REG_AW-1:0] ex_rs1,
    input  logic [REG_AW-1:0] ex_rs2,
    input  logic              ex_rs1_use,
    input  logic              ex_rs2_use,
    input  logic              mem_valid,
    input  logic [REG_AW-1:0] mem_rd,
    input  logic              mem_wen,
    input  logic              mem_is_load,
    input  logic              mem_is_store,
    input  logic [REG_AW-1:0] mem_rs2,
    input  logic              wb_valid,
    input  logic [REG_AW-1:0] wb_rd,
    input  logic              wb_wen,
    input  logic              wb_is_load,
    output logic              stall_pc,
    output logic              stall_ifid,
    output logic              bubble_ex,
    output logic              bubble_id,
    output logic [1:0]        fwd_a,
    output logic [1:0]        fwd_b,
    output logic              fwd_sd,
    output logic [CNT_W-1:0]  cycle_cnt,
    output logic [CNT_W-1:0]  retire_cnt
);

    localparam int NUM_SRC = 2;

    logic [NUM_SRC-1:0][REG_AW-1:0] dec_src;
    logic [NUM_SRC-1:0]             dec_alu_use;
    logic [NUM_SRC-1:0]             dec_any_use;
    logic [NUM_SRC-1:0]             dec_haz;
    logic [NUM_SRC-1:0][REG_AW-1:0] exe_src;
    logic [NUM_SRC-1:0]             exe_use;
    op_sel_e                        exe_sel [NUM_SRC];

    logic data_hazard, rf_conflict, mem_conflict, dec_reads;

    // Gather decode and execute sources into arrays for the generated slices.
    always_comb begin
        dec_src[0]     = id_rs1;
        dec_src[1]     = id_rs2;
        dec_alu_use[0] = id_rs1_use;
        dec_alu_use[1] = id_rs2_use;
        dec_any_use[0] = id_rs1_use;
        dec_any_use[1] = id_rs2_use || id_is_store;
        exe_src[0]     = ex_rs1;
        exe_src[1]     = ex_rs2;
        exe_use[0]     = ex_rs1_use;
        exe_use[1]     = ex_rs2_use;
    end

    for (genvar g = 0; g < NUM_SRC; g++) begin : g_src
        pi_src_hazard #(.REG_AW(REG_AW)) u_haz (
            .cfg_fwd_en   (cfg_fwd_en),
            .cfg_split_rf (cfg_split_rf),
            .src          (dec_src[g]),
            .alu_use      (dec_alu_use[g]),
            .any_use      (dec_any_use[g]),
            .ex_valid     (ex_valid),
            .ex_rd        (ex_rd),
            .ex_wen       (ex_wen),
            .ex_is_load   (ex_is_load),
            .mem_valid    (mem_valid),
            .mem_rd       (mem_rd),
            .mem_wen      (mem_wen),
            .wb_valid     (wb_valid),
            .wb_rd        (wb_rd),
            .wb_wen       (wb_wen),
            .hazard       (dec_haz[g])
        );

        pi_fwd_sel #(.REG_AW(REG_AW)) u_fwd (
            .cfg_fwd_en  (cfg_fwd_en),
            .src         (exe_src[g]),
            .src_use     (exe_use[g]),
            .mem_valid   (mem_valid),
            .mem_rd      (mem_rd),
            .mem_wen     (mem_wen),
            .mem_is_load (mem_is_load),
            .wb_valid    (wb_valid),
            .wb_rd       (wb_rd),
            .wb_wen      (wb_wen),
            .sel         (exe_sel[g])
        );
    end

    // Structural causes and the combined data hazard.
    always_comb begin
        dec_reads    = id_rs1_use || id_rs2_use || id_is_store;
        data_hazard  = id_valid && (|dec_haz);
        rf_conflict  = !cfg_split_rf && id_valid && dec_reads
                       && wb_valid && wb_wen && (wb_rd != '0);
        mem_conflict = !cfg_split_mem && mem_valid && (mem_is_load || mem_is_store);
    end

    pi_stall_ctrl u_stall (
        .data_hazard  (data_hazard),
        .rf_conflict  (rf_conflict),
        .mem_conflict (mem_conflict),
        .stall_pc     (stall_pc),
        .stall_ifid   (stall_ifid),
        .bubble_ex    (bubble_ex),
        .bubble_id    (bubble_id)
    );

    // Drive operand selects and the late store-data bypass.
    always_comb begin
        fwd_a  = exe_sel[0];
        fwd_b  = exe_sel[1];
        fwd_sd = cfg_fwd_en && mem_valid && mem_is_store && (mem_rs2 != '0)
                 && wb_valid && wb_wen && wb_is_load && (wb_rd == mem_rs2);
    end

    pi_event_cnt #(.CNT_W(CNT_W)) u_cyc (
        .clk   (clk),
        .rst_n (rst_n),
        .inc   (1'b1),
        .count (cycle_cnt)
    );

    pi_event_cnt #(.CNT_W(CNT_W)) u_ret (
        .clk   (clk),
        .rst_n (rst_n),
        .inc   (wb_valid),
        .count (retire_cnt)
    );

endmodule

// File: rtl/pipe_interlock_chk.sv
// Module: pipe_interlock_chk
// Property checker bound to pipe_interlock; observes ports only.
module pipe_interlock_chk #(
    parameter int REG_AW = 5,
    parameter int CNT_W  = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cfg_fwd_en,
    input logic              cfg_split_mem,
    input logic              cfg_split_rf,
    input logic              id_valid,
    input logic [REG_AW-1:0] id_rs1,
    input logic              id_rs1_use,
    input logic              ex_valid,
    input logic [REG_AW-1:0] ex_rd,
    input logic              ex_wen,
    input logic              ex_is_load,
    input logic [REG_AW-1:0] ex_rs1,
    input logic              mem_valid,
    input logic [REG_AW-1:0] mem_rd,
    input logic              mem_wen,
    input logic              mem_is_load,
    input logic              mem_is_store,
    input logic              wb_valid,
    input logic              stall_pc,
    input logic              stall_ifid,
    input logic              bubble_ex,
    input logic              bubble_id,
    input logic [1:0]        fwd_a,
    input logic [1:0]        fwd_b,
    input logic              fwd_sd,
    input logic [CNT_W-1:0]  cycle_cnt,
    input logic [CNT_W-1:0]  retire_cnt
);

    p_mem_port_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (!cfg_split_mem && mem_valid && (mem_is_load || mem_is_store)) |-> stall_pc);

    p_load_use_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_fwd_en && id_valid && id_rs1_use && ex_valid && ex_wen && ex_is_load
         && ex_rd != '0 && ex_rd == id_rs1) |-> bubble_ex);

    p_zero_reg_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (fwd_a != 2'd0) |-> (ex_rs1 != '0));

    p_prio_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (fwd_a == 2'd1) |-> (mem_valid && mem_wen && !mem_is_load && mem_rd == ex_rs1));

    p_bubble_excl_r9: assert property (@(posedge clk) disable iff (!rst_n)
        bubble_ex |-> (stall_ifid && stall_pc && !bubble_id));

    p_fetch_bubble_r9: assert property (@(posedge clk) disable iff (!rst_n)
        bubble_id |-> (stall_pc && !stall_ifid));

    p_cycle_cnt_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (cycle_cnt == $past(cycle_cnt) + CNT_W'(1)));

    p_retire_cnt_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (retire_cnt == $past(retire_cnt) + CNT_W'($past(wb_valid))));

    p_fwd_off_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_fwd_en |-> (fwd_a == 2'd0 && fwd_b == 2'd0 && !fwd_sd));

    p_split_rf_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_split_rf && !cfg_fwd_en && !ex_valid && !mem_valid) |-> !stall_ifid);

endmodule

bind pipe_interlock pipe_interlock_chk #(.REG_AW(REG_AW), .CNT_W(CNT_W)) u_chk (.*);

// File: tb/pipe_interlock_bench.sv
// Bench: sweeps the interlock over three register numbers, all stage kinds and modes.
module pipe_interlock_bench;

    localparam int AW = 5;
    localparam int CW = 32;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cfg_fwd_en = 0, cfg_split_mem = 0, cfg_split_rf = 0;
    logic id_valid = 0, id_rs1_use = 0, id_rs2_use = 0, id_is_store = 0;
    logic [AW-1:0] id_rs1 = '0, id_rs2 = '0;
    logic ex_valid = 0, ex_wen = 0, ex_is_load = 0, ex_rs1_use = 0, ex_rs2_use = 0;
    logic [AW-1:0] ex_rd = '0, ex_rs1 = '0, ex_rs2 = '0;
    logic mem_valid = 0, mem_wen = 0, mem_is_load = 0, mem_is_store = 0;
    logic [AW-1:0] mem_rd = '0, mem_rs2 = '0;
    logic wb_valid = 0, wb_wen = 0, wb_is_load = 0;
    logic [AW-1:0] wb_rd = '0;
    logic stall_pc, stall_ifid, bubble_ex, bubble_id, fwd_sd;
    logic [1:0] fwd_a, fwd_b;
    logic [CW-1:0] cycle_cnt, retire_cnt;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 0;

    always #5 clk = ~clk;

    pipe_interlock #(.REG_AW(AW), .CNT_W(CW)) u_pipe_interlock (.*);

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            if (n_fail < 20) $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic logic [1:0] exp_sel(int s, bit u, bit f, int mk, int md, bit ww, int wd);
        if (!f || !u || s == 0) return 2'd0;
        if (mk == 1 && md == s) return 2'd1;
        if (ww && wd == s) return 2'd2;
        return 2'd0;
    endfunction

    task automatic set_mem(input int mk, input int md);
        mem_valid    = (mk != 0);
        mem_wen      = (mk == 1 || mk == 2);
        mem_is_load  = (mk == 2);
        mem_is_store = (mk == 3);
        mem_rd       = AW'(md);
    endtask

    // Watchdog: a hung run counts as one failed check.
    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=1 expected=0");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        int k;
        // Reset state (R10).
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk(cycle_cnt == 0, "R10 cycle reset", int'(cycle_cnt), 0);
        chk(retire_cnt == 0, "R10 retire reset", int'(retire_cnt), 0);
        rst_n = 1'b1;
        k = 0;
        for (int i = 0; i < 20; i++) begin
            wb_valid = (i % 3 != 1);
            if (wb_valid) k++;
            @(negedge clk);
        end
        wb_valid = 0;
        chk(cycle_cnt == 20, "R10 cycle count", int'(cycle_cnt), 20);
        chk(retire_cnt == CW'(k), "R10 retire count", int'(retire_cnt), k);

        // Sweep 1: decode and fetch stalls over modes and stage kinds.
        id_valid = 1;
        for (int m = 0; m < 8; m++)
        for (int idk = 0; idk < 4; idk++)
        for (int exk = 0; exk < 3; exk++)
        for (int mk = 0; mk < 4; mk++)
        for (int ww = 0; ww < 2; ww++)
        for (int r1 = 0; r1 < 3; r1++)
        for (int r2 = 0; r2 < 3; r2++)
        for (int er = 0; er < 3; er++)
        for (int mr = 0; mr < 3; mr++)
        for (int wr = 0; wr < 3; wr++) begin
            bit f, sm, sr, u1, u2a, u2s, rdany, exw, exld, memw, wbw, dh, rfc, ds, fc, sdonly;
            string dtag;
            f = m[0]; sm = m[1]; sr = m[2];
            cfg_fwd_en = f; cfg_split_mem = sm; cfg_split_rf = sr;
            id_rs1_use  = (idk == 0 || idk == 1 || idk == 2);
            id_rs2_use  = (idk == 0);
            id_is_store = (idk == 2);
            id_rs1 = AW'(r1); id_rs2 = AW'(r2);
            ex_valid = (exk != 0); ex_wen = (exk != 0); ex_is_load = (exk == 2); ex_rd = AW'(er);
            set_mem(mk, mr);
            wb_valid = ww[0]; wb_wen = ww[0]; wb_rd = AW'(wr);
            #1;
            u1  = id_rs1_use && r1 != 0;
            u2a = id_rs2_use && r2 != 0;
            u2s = id_is_store && r2 != 0;
            rdany = id_rs1_use || id_rs2_use || id_is_store;
            exw  = exk != 0 && er != 0;
            exld = exk == 2;
            memw = (mk == 1 || mk == 2) && mr != 0;
            wbw  = ww != 0 && wr != 0;
            if (f) begin
                dh = exw && exld && ((u1 && er == r1) || (u2a && er == r2));
            end else begin
                dh = (u1 && ((exw && er == r1) || (memw && mr == r1) || (!sr && wbw && wr == r1)))
                  || ((u2a || u2s) && ((exw && er == r2) || (memw && mr == r2) || (!sr && wbw && wr == r2)));
            end
            rfc = !sr && wbw && rdany;
            ds  = dh || rfc;
            fc  = !sm && mk >= 2;
            sdonly = f && u2s && exw && exld && er == r2;
            if (rfc) dtag = "R2";
            else if (sdonly) dtag = "R8 store data";
            else if (sr && wbw && !dh) dtag = "R3";
            else if ((r1 == 0 || r2 == 0) && !ds) dtag = "R6";
            else if (f) dtag = "R5";
            else dtag = "R4";
            chk(stall_ifid == ds, dtag, int'(stall_ifid), int'(ds));
            chk({stall_pc, bubble_ex, bubble_id} == {ds | fc, ds, fc & !ds},
                fc ? "R1" : "R9", int'({stall_pc, bubble_ex, bubble_id}),
                int'({ds | fc, ds, fc & !ds}));
            #1;
        end

        // Sweep 2: execute operand selects and store-data bypass.
        ex_valid = 1; ex_wen = 0; ex_is_load = 0; ex_rd = '0;
        for (int f = 0; f < 2; f++)
        for (int u = 0; u < 4; u++)
        for (int mk = 0; mk < 4; mk++)
        for (int ww = 0; ww < 2; ww++)
        for (int wl = 0; wl < 2; wl++)
        for (int a1 = 0; a1 < 3; a1++)
        for (int a2 = 0; a2 < 3; a2++)
        for (int md = 0; md < 3; md++)
        for (int wd = 0; wd < 3; wd++)
        for (int ms = 0; ms < 3; ms++) begin
            logic [1:0] ea, eb;
            bit esd;
            string stag;
            cfg_fwd_en = f[0];
            ex_rs1_use = u[0]; ex_rs2_use = u[1];
            ex_rs1 = AW'(a1); ex_rs2 = AW'(a2);
            set_mem(mk, md); mem_rs2 = AW'(ms);
            wb_valid = ww[0]; wb_wen = ww[0]; wb_is_load = wl[0]; wb_rd = AW'(wd);
            #1;
            ea  = exp_sel(a1, u[0], f[0], mk, md, ww[0], wd);
            eb  = exp_sel(a2, u[1], f[0], mk, md, ww[0], wd);
            esd = f[0] && mk == 3 && ms != 0 && ww[0] && wl[0] && wd == ms;
            if (f == 0) stag = "R11";
            else if (a1 == 0 || a2 == 0) stag = "R6";
            else stag = "R7";
            chk(fwd_a == ea, stag, int'(fwd_a), int'(ea));
            chk(fwd_b == eb, stag, int'(fwd_b), int'(eb));
            chk(fwd_sd == esd, (f == 0) ? "R11" : "R8", int'(fwd_sd), int'(esd));
            #1;
        end

        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule